// File: doc/BRIEF.md
# Shuttle Balancer Fault Supervisor

This block watches the energy-shuttle stage of an active cell balancer and the charger that schedules it, and decides whether the shuttle may run at all. It keeps two groups of causes apart. Hard causes stop the shuttle through a latched disable: a broken or shorted transfer path, a target cell hotter than its limit, a charger fault, or a cell imbalance that does not shrink during the constant-voltage phase. Soft causes only reduce the shuttle's effort: a warm pack or ambient that is still inside its valid window, or a charge current that the thermal profile has already cut back. Unevenly heated cells are fenced off one by one through a per-cell inhibit mask instead of stopping the whole balancer.

Each new stop is reported to the host as a fault code over a valid/ready stream. The block drives no pack switch. The host reads the report, removes the cause, and then writes a clear. The clear has no effect while any hard cause is still present.

Top module: `bal_guard`

## Requirements
- R1: An asserted `path_open` or `path_short` in a cycle makes `bal_disable` high after the next clock edge.
- R2: `cell_temp` strictly greater than `temp_limit` makes `bal_disable` high after the next clock edge. Equality is not an overtemperature.
- R3: An asserted `chg_fault` makes `bal_disable` high after the next clock edge.
- R4: Outside the constant-voltage phase (`cv_phase` low), the monitor takes `cell_diff` as its reference, zeroes its period count and drops its non-convergence flag. In the phase, each `eval_tick` works as follows. If `cell_diff + conv_margin <= reference`, the reference becomes `cell_diff` and the count returns to 0. Otherwise the count increments, saturating at its maximum. When the incremented count reaches `conv_periods`, the flag sets and stays set until the phase ends. The flag is a hard cause, with a one-cycle lag on `bal_disable`.
- R5: `bal_disable` stays high until a `clr` arrives in a cycle with no hard cause present. It then falls after that edge. A `clr` in a cycle with a hard cause is ignored.
- R6: `rpt_code` encodings are 1 path fault, 2 overtemperature, 3 charger fault, 4 non-convergence, and 0 only at reset. When causes coincide, the lowest non-zero code wins.
- R7: Report stream rules:
  - A report is raised on the edge where `bal_disable` goes from low to high.
  - `rpt_valid` and `rpt_code` stay stable while `rpt_ready` is low.
  - A transfer completes on an edge with both `rpt_valid` and `rpt_ready` high.
  - A new stop that arrives while an earlier report is still waiting (valid high, ready low) is dropped, and the earlier code is kept.
- R8: `derate_lvl` equals the number of asserted inputs among `amb_warm` and `curr_reduced` (0..2), registered one cycle. These inputs never affect `bal_disable`.
- R9: `cell_inhibit` bit i equals `cell_hot` bit i, registered one cycle. Hot cells never affect `bal_disable`.
- R10: After reset, `bal_disable`, `derate_lvl`, `cell_inhibit`, `rpt_valid` and `rpt_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_open | input | 1 | Shuttle transfer path detected open |
| path_short | input | 1 | Shuttle transfer path detected shorted |
| cell_temp | input | TEMP_W | Target cell temperature code |
| temp_limit | input | TEMP_W | Overtemperature limit code |
| chg_fault | input | 1 | Charger reports a fault |
| cv_phase | input | 1 | Charger is in constant-voltage phase |
| eval_tick | input | 1 | One-cycle strobe marking an evaluation period |
| cell_diff | input | DIFF_W | Current max-min cell voltage difference |
| conv_margin | input | DIFF_W | Required drop per evaluation window |
| conv_periods | input | PER_W | Non-improving periods that count as non-convergence |
| amb_warm | input | 1 | Pack or ambient warm but within range |
| curr_reduced | input | 1 | Charge current already cut by thermal profile |
| cell_hot | input | N_CELLS | Per-cell hot-spot flags |
| clr | input | 1 | Host clear of the latched disable |
| rpt_ready | input | 1 | Host accepts the fault report |
| bal_disable | output | 1 | Latched shuttle stop |
| derate_lvl | output | 2 | Shuttle derate level |
| cell_inhibit | output | N_CELLS | Per-cell shuttle inhibit mask |
| rpt_valid | output | 1 | Fault report pending |
| rpt_code | output | 3 | Fault report code |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across the sampling edge, that `eval_tick` is a single-cycle strobe, and that the host holds `rpt_ready` as a level rather than a glitch. The stimulus changes inputs only on the falling edge. It pulses `eval_tick` for exactly one cycle. It keeps `rpt_ready` low for several cycles at a time so that the stall and drop rules are exercised. Hard causes are applied alone and together, and they are removed before each clear that is meant to succeed.

// File: rtl/bal_guard_pkg.sv
package bal_guard_pkg;
  typedef enum logic [2:0] {
    CODE_NONE  = 3'd0,
    CODE_PATH  = 3'd1,
    CODE_OVT   = 3'd2,
    CODE_CHG   = 3'd3,
    CODE_NCONV = 3'd4
  } fault_code_e;
endpackage

// File: rtl/bal_conv_monitor.sv
module bal_conv_monitor #(
  parameter int DIFF_W = 12,
  parameter int PER_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_phase,
  input  logic              eval_tick,
  input  logic [DIFF_W-1:0] cell_diff,
  input  logic [DIFF_W-1:0] conv_margin,
  input  logic [PER_W-1:0]  conv_periods,
  output logic              nconv
);
  localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};

  logic [DIFF_W-1:0] ref_q;
  logic [PER_W-1:0]  cnt_q;
  logic [DIFF_W:0]   target_sum;
  logic              improved;
  logic [PER_W:0]    cnt_inc;

  assign target_sum = {1'b0, cell_diff} + {1'b0, conv_margin};
  assign improved   = target_sum <= {1'b0, ref_q};
  assign cnt_inc    = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      cnt_q <= '0;
      nconv <= 1'b0;
    end else if (!cv_phase) begin
      ref_q <= cell_diff;
      cnt_q <= '0;
      nconv <= 1'b0;
    end else if (eval_tick) begin
      if (improved) begin
        ref_q <= cell_diff;
        cnt_q <= '0;
      end else begin
        if (cnt_inc >= {1'b0, conv_periods}) nconv <= 1'b1;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_inc[PER_W-1:0];
      end
    end
  end

  // R4
  nconv_clears_outside_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cv_phase |=> !nconv);

  // R4
  nconv_sticky_in_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nconv && cv_phase |=> nconv);
endmodule

// File: rtl/bal_fault_latch.sv
module bal_fault_latch
  import bal_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        path_fault,
  input  logic        over_temp,
  input  logic        chg_fault,
  input  logic        nconv,
  input  logic        clr,
  input  logic        rpt_ready,
  output logic        bal_disable,
  output logic        rpt_valid,
  output fault_code_e rpt_code
);
  logic        any_cause;
  logic        stop_event;
  logic        slot_free;
  fault_code_e top_code;

  assign any_cause  = path_fault | over_temp | chg_fault | nconv;
  assign stop_event = any_cause & ~bal_disable;
  assign slot_free  = ~rpt_valid | rpt_ready;

  always_comb begin
    if (path_fault)     top_code = CODE_PATH;
    else if (over_temp) top_code = CODE_OVT;
    else if (chg_fault) top_code = CODE_CHG;
    else if (nconv)     top_code = CODE_NCONV;
    else                top_code = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bal_disable <= 1'b0;
    end else if (any_cause) begin
      bal_disable <= 1'b1;
    end else if (clr) begin
      bal_disable <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid <= 1'b0;
      rpt_code  <= CODE_NONE;
    end else if (stop_event && slot_free) begin
      rpt_valid <= 1'b1;
      rpt_code  <= top_code;
    end else if (rpt_valid && rpt_ready) begin
      rpt_valid <= 1'b0;
    end
  end

  // R1
  path_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_fault |=> bal_disable);

  // R3
  charger_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_fault |=> bal_disable);

  // R5
  disable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bal_disable && !clr |=> bal_disable);

  // R7
  report_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_code));

  // R6
  report_code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> rpt_code != CODE_NONE);
endmodule

// File: rtl/bal_derate_map.sv
module bal_derate_map #(
  parameter int N_CELLS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               amb_warm,
  input  logic               curr_reduced,
  input  logic [N_CELLS-1:0] cell_hot,
  output logic [1:0]         derate_lvl,
  output logic [N_CELLS-1:0] cell_inhibit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) derate_lvl <= 2'd0;
    else        derate_lvl <= {1'b0, amb_warm} + {1'b0, curr_reduced};
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_inhibit[i] <= 1'b0;
      else        cell_inhibit[i] <= cell_hot[i];
    end
  end

  // R8
  derate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    derate_lvl <= 2'd2);

  // R8
  derate_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amb_warm && curr_reduced |=> derate_lvl == 2'd2);
endmodule

// File: rtl/bal_guard.sv
module bal_guard
  import bal_guard_pkg::*;
#(
  parameter int N_CELLS = 6,
  parameter int TEMP_W  = 8,
  parameter int DIFF_W  = 12,
  parameter int PER_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               path_open,
  input  logic               path_short,
  input  logic [TEMP_W-1:0]  cell_temp,
  input  logic [TEMP_W-1:0]  temp_limit,
  input  logic               chg_fault,
  input  logic               cv_phase,
  input  logic               eval_tick,
  input  logic [DIFF_W-1:0]  cell_diff,
  input  logic [DIFF_W-1:0]  conv_margin,
  input  logic [PER_W-1:0]   conv_periods,
  input  logic               amb_warm,
  input  logic               curr_reduced,
  input  logic [N_CELLS-1:0] cell_hot,
  input  logic               clr,
  input  logic               rpt_ready,
  output logic               bal_disable,
  output logic [1:0]         derate_lvl,
  output logic [N_CELLS-1:0] cell_inhibit,
  output logic               rpt_valid,
  output logic [2:0]         rpt_code
);
  logic        path_fault;
  logic        over_temp;
  logic        nconv;
  fault_code_e code_q;

  assign path_fault = path_open | path_short;
  assign over_temp  = cell_temp > temp_limit;
  assign rpt_code   = code_q;

  bal_conv_monitor #(.DIFF_W(DIFF_W), .PER_W(PER_W)) conv_i (
    .clk(clk), .rst_n(rst_n), .cv_phase(cv_phase), .eval_tick(eval_tick),
    .cell_diff(cell_diff), .conv_margin(conv_margin),
    .conv_periods(conv_periods), .nconv(nconv)
  );

  bal_fault_latch latch_i (
    .clk(clk), .rst_n(rst_n), .path_fault(path_fault), .over_temp(over_temp),
    .chg_fault(chg_fault), .nconv(nconv), .clr(clr), .rpt_ready(rpt_ready),
    .bal_disable(bal_disable), .rpt_valid(rpt_valid), .rpt_code(code_q)
  );

  bal_derate_map #(.N_CELLS(N_CELLS)) derate_i (
    .clk(clk), .rst_n(rst_n), .amb_warm(amb_warm), .curr_reduced(curr_reduced),
    .cell_hot(cell_hot), .derate_lvl(derate_lvl), .cell_inhibit(cell_inhibit)
  );

  // R2
  overtemp_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_temp > temp_limit |=> bal_disable);
endmodule

// File: tb/bal_guard_tb_top.sv
module bal_guard_tb_top;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic path_open = 0, path_short = 0, chg_fault = 0, cv_phase = 0, eval_tick = 0;
  logic [7:0] cell_temp = 8'd40, temp_limit = 8'd60;
  logic [11:0] cell_diff = 12'd0, conv_margin = 12'd10;
  logic [3:0] conv_periods = 4'd3;
  logic amb_warm = 0, curr_reduced = 0, clr = 0, rpt_ready = 1;
  logic [NC-1:0] cell_hot = '0;
  logic bal_disable, rpt_valid;
  logic [1:0] derate_lvl;
  logic [NC-1:0] cell_inhibit;
  logic [2:0] rpt_code;

  int checks = 0, failures = 0;
  bit done = 0;
  string req = "R10";

  int m_dis = 0, m_lvl = 0, m_mask = 0, m_rv = 0, m_code = 0;
  int m_ref = 0, m_cnt = 0, m_nc = 0;

  always #2 clk = ~clk;

  bal_guard #(.N_CELLS(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .path_open(path_open), .path_short(path_short),
    .cell_temp(cell_temp), .temp_limit(temp_limit), .chg_fault(chg_fault),
    .cv_phase(cv_phase), .eval_tick(eval_tick), .cell_diff(cell_diff),
    .conv_margin(conv_margin), .conv_periods(conv_periods), .amb_warm(amb_warm),
    .curr_reduced(curr_reduced), .cell_hot(cell_hot), .clr(clr),
    .rpt_ready(rpt_ready), .bal_disable(bal_disable), .derate_lvl(derate_lvl),
    .cell_inhibit(cell_inhibit), .rpt_valid(rpt_valid), .rpt_code(rpt_code)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int cause, code, nd, nrv, ncode, nref, ncnt, nnc;
    cause = (path_open || path_short || (cell_temp > temp_limit) || chg_fault || m_nc) ? 1 : 0;
    code = (path_open || path_short) ? 1 : (cell_temp > temp_limit) ? 2 :
           chg_fault ? 3 : m_nc ? 4 : 0;
    nrv = m_rv; ncode = m_code;
    if (cause && !m_dis && (!m_rv || rpt_ready)) begin nrv = 1; ncode = code; end
    else if (m_rv && rpt_ready) nrv = 0;
    nd = cause ? 1 : (clr ? 0 : m_dis);
    nref = m_ref; ncnt = m_cnt; nnc = m_nc;
    if (!cv_phase) begin nref = int'(cell_diff); ncnt = 0; nnc = 0; end
    else if (eval_tick) begin
      if (int'(cell_diff) + int'(conv_margin) <= m_ref) begin nref = int'(cell_diff); ncnt = 0; end
      else begin
        if (m_cnt + 1 >= int'(conv_periods)) nnc = 1;
        if (m_cnt < 15) ncnt = m_cnt + 1;
      end
    end
    m_dis = nd; m_rv = nrv; m_code = ncode; m_ref = nref; m_cnt = ncnt; m_nc = nnc;
    m_lvl = int'(amb_warm) + int'(curr_reduced);
    m_mask = int'(cell_hot);
  endtask

  task automatic compare_all();
    chk("bal_disable", int'(bal_disable), m_dis);
    chk("derate_lvl", int'(derate_lvl), m_lvl);
    chk("cell_inhibit", int'(cell_inhibit), m_mask);
    chk("rpt_valid", int'(rpt_valid), m_rv);
    if (m_rv) chk("rpt_code", int'(rpt_code), m_code);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      eval_tick = 0;
    end
  endtask

  task automatic tick(logic [11:0] d);
    cell_diff = d; eval_tick = 1; cyc(1); cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("reset bal_disable", int'(bal_disable), 0);
    chk("reset derate_lvl", int'(derate_lvl), 0);
    chk("reset cell_inhibit", int'(cell_inhibit), 0);
    chk("reset rpt_valid", int'(rpt_valid), 0);
    chk("reset rpt_code", int'(rpt_code), 0);
    rst_n = 1;
    cyc(2);

    // R8 / R9: derate and per-cell inhibit, never a stop
    req = "R8"; amb_warm = 1; cyc(2);
    curr_reduced = 1; cyc(2);
    amb_warm = 0; cyc(1);
    req = "R9"; cell_hot = 6'b100101; cyc(2);
    cell_hot = 6'b011010; curr_reduced = 0; cyc(2);
    cell_hot = '0; cyc(1);

    // R1: path open pulse, report stalls (R7)
    req = "R1"; rpt_ready = 0; path_open = 1; cyc(1);
    path_open = 0; req = "R7"; cyc(4);
    rpt_ready = 1; cyc(2);
    // R5: clear while path short present is ignored
    req = "R5"; path_short = 1; clr = 1; cyc(2);
    path_short = 0; cyc(1); clr = 0; cyc(2);

    // R2: equality is no overtemp, above is
    req = "R2"; cell_temp = 8'd60; cyc(3);
    cell_temp = 8'd61; cyc(2);
    cell_temp = 8'd40; clr = 1; cyc(1); clr = 0; cyc(1);

    // R6: priority with coincident causes
    req = "R6"; cell_temp = 8'd70; chg_fault = 1; path_short = 1; cyc(2);
    path_short = 0; cell_temp = 8'd40; chg_fault = 0; clr = 1; cyc(1); clr = 0;
    cell_temp = 8'd70; chg_fault = 1; cyc(2);
    cell_temp = 8'd40; chg_fault = 0; clr = 1; cyc(1); clr = 0;
    // R3: charger fault alone
    req = "R3"; chg_fault = 1; cyc(2);
    chg_fault = 0; clr = 1; cyc(1); clr = 0; cyc(1);

    // R4: converging imbalance in CV never stops
    req = "R4"; cell_diff = 12'd100; cyc(1);
    cv_phase = 1; cyc(1);
    tick(12'd85); tick(12'd80); tick(12'd70); tick(12'd60); tick(12'd55);
    tick(12'd45); cyc(2);
    // non-converging: small drops only
    tick(12'd44); tick(12'd40); tick(12'd38); cyc(3);
    clr = 1; cyc(2); clr = 0;
    cv_phase = 0; cyc(1);
    clr = 1; cyc(1); clr = 0; cyc(2);
    // re-entering CV with one period limit
    conv_periods = 4'd1; cell_diff = 12'd200; cv_phase = 1; cyc(1);
    tick(12'd199); cyc(2);
    cv_phase = 0; clr = 1; cyc(1); clr = 0; cyc(1);

    // R7: new stop while a report waits is dropped
    req = "R7"; rpt_ready = 0; path_open = 1; cyc(1); path_open = 0;
    clr = 1; cyc(1); clr = 0;
    chg_fault = 1; cyc(3);
    rpt_ready = 1; cyc(2);
    chg_fault = 0; clr = 1; cyc(1); clr = 0; cyc(3);

    finish_run();
  end
endmodule